// File: doc/BRIEF.md
# DDR Prefetch Burst Gearbox

This block sits between a memory core and the pin logic of a double-data-rate interface. On the read side the core hands over one prefetch word per clock. The word is four pin beats wide. The block turns one or two such words into a burst of 4 or 8 pin beats, with two beats per clock. The beat for the first half of the clock goes on a rising-phase lane and the beat for the second half goes on a falling-phase lane. Each byte lane gets its own strobe. During a read the strobe switches together with the data. A low preamble comes before the burst and a half-clock low postamble follows it.

On the write side the block takes pin beats in pairs and rebuilds prefetch words. Each byte lane has its own strobe flags: one marks the strobe edge in the middle of the rising-phase beat, the other marks the edge in the middle of the falling-phase beat. Each byte lane collects its share of a word on its own timing. The full word is presented to the core once every lane has filled.

Half-clock timing is modelled by the separate rising and falling lanes inside one clock domain. Analog pad behaviour, phase alignment, termination and drive strength are not modelled.

Top module: `ddr_burst_gearbox`

## Requirements
- R1: After reset, `dq_oe`, every bit of `dqs_oe_rise`/`dqs_oe_fall` and `wr_valid` are 0, and `rd_ready` is 1.
- R2: In the clock after a first read word is accepted (`rd_valid` and `rd_ready` both high at an edge), every byte lane's strobe is enabled in both phases and driven low, and `dq_oe` is 0 (preamble).
- R3: In the beat clocks of a read word, clock k (k = 0, 1) drives pin beat 2k on `dq_rise` and beat 2k+1 on `dq_fall`. Beat i is taken from word bits [i*DQ_W +: DQ_W]. While `dq_oe` is 1, every `dqs_rise` bit is 1 and every `dqs_fall` bit is 0.
- R4: `bl8_cfg` is sampled only when the first word is accepted: 0 gives a 4-beat burst from one word, 1 gives an 8-beat burst from two words. Changing it mid-burst has no effect.
- R5: In an 8-beat burst, `rd_ready` is 1 in the second beat clock of the first word. If `rd_valid` is 1 there, beats 4 to 7 follow in the next two clocks without a gap.
- R6: If the second word is not offered in time, serialization stalls: `dq_oe` is 0, the strobes stay enabled and low, and `rd_ready` stays 1. The clock after the word is accepted drives beats 4 and 5.
- R7: In the clock after the last beat, each strobe is enabled in the rising phase only and driven low (postamble). In the next clock all strobe enables are 0.
- R8: `rd_ready` is 0 in the preamble, in the first beat clock of each word and in the postamble. A `rd_valid` offered there is ignored.
- R9: A byte lane captures `wr_dq_rise`/`wr_dq_fall` in a clock where both of its strobe flags are 1. Its first pair becomes beats 0 and 1 and its second pair becomes beats 2 and 3. Byte b of beat k goes to `wr_word` bits [k*DQ_W + 8*b +: 8].
- R10: `wr_valid` is 1 for exactly one clock, in the clock after the last byte lane fills, and carries the assembled word. A pair arriving in that filling clock's successor is captured as the start of the next word.
- R11: A clock in which a lane has only one of its two strobe flags set captures nothing. A lane that is already full ignores further pairs until the word is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bl8_cfg | input | 1 | Burst length select, 1 = 8 beats |
| rd_valid | input | 1 | Read prefetch word offered |
| rd_word | input | 4*DQ_W | Read prefetch word |
| rd_ready | output | 1 | Read word taken at this edge when valid |
| dq_oe | output | 1 | Read data driven this clock |
| dq_rise | output | DQ_W | Read beat for first half clock |
| dq_fall | output | DQ_W | Read beat for second half clock |
| dqs_oe_rise | output | DQ_W/8 | Per-lane strobe enable, first half |
| dqs_oe_fall | output | DQ_W/8 | Per-lane strobe enable, second half |
| dqs_rise | output | DQ_W/8 | Per-lane strobe level, first half |
| dqs_fall | output | DQ_W/8 | Per-lane strobe level, second half |
| wr_dq_rise | input | DQ_W | Write beat at first-half strobe edge |
| wr_dq_fall | input | DQ_W | Write beat at second-half strobe edge |
| wr_dqs_rise | input | DQ_W/8 | Per-lane first-half strobe edge seen |
| wr_dqs_fall | input | DQ_W/8 | Per-lane second-half strobe edge seen |
| wr_valid | output | 1 | Assembled write word valid |
| wr_word | output | 4*DQ_W | Assembled write word |

## Verification
The bench builds the block with the default DQ_W of 16. That gives two byte lanes and a 64-bit prefetch word. With two lanes the bench can hold the strobe timing of one lane apart from the other, so skewed filling, a lane that fills early and ignores a pair, and a one-edge clock are all exercised. The read table mixes 4-beat and 8-beat bursts, with stalls of zero, one and three clocks before the second word.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int LANE_W         = 8;
    localparam int BEATS_PER_WORD = 4;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_PRE,
        RS_BEAT,
        RS_WAIT,
        RS_POST
    } rd_state_e;

    // position inside a burst: which word, which half of it
    typedef struct packed {
        logic second;
        logic half;
    } beat_pos_t;

    function automatic int lane_bit(input int beat, input int lane, input int dq_w);
        return beat * dq_w + lane * LANE_W;
    endfunction

endpackage

// File: rtl/dbg_rd_serializer.sv
module dbg_rd_serializer
    import dbg_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bl8_cfg,
    input  logic                 rd_valid,
    input  logic [4*DQ_W-1:0]    rd_word,
    output logic                 rd_ready,
    output logic                 dq_oe,
    output logic [DQ_W-1:0]      dq_rise,
    output logic [DQ_W-1:0]      dq_fall,
    output logic                 strb_en_r,
    output logic                 strb_en_f,
    output logic                 strb_r,
    output logic                 strb_f
);

    localparam int WORD_W = BEATS_PER_WORD * DQ_W;

    rd_state_e           st_q;
    beat_pos_t           pos_q;
    logic                bl8_q;
    logic [WORD_W-1:0]   word_q;
    logic                more_words;

    assign more_words = bl8_q && !pos_q.second;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RS_IDLE;
            pos_q  <= '0;
            bl8_q  <= 1'b0;
            word_q <= '0;
        end else begin
            case (st_q)
                RS_IDLE: begin
                    if (rd_valid) begin
                        word_q <= rd_word;
                        bl8_q  <= bl8_cfg;
                        pos_q  <= '0;
                        st_q   <= RS_PRE;
                    end
                end
                RS_PRE: st_q <= RS_BEAT;
                RS_BEAT: begin
                    if (!pos_q.half) begin
                        pos_q.half <= 1'b1;
                    end else begin
                        pos_q.half <= 1'b0;
                        if (more_words) begin
                            pos_q.second <= 1'b1;
                            if (rd_valid) begin
                                word_q <= rd_word;
                            end else begin
                                st_q <= RS_WAIT;
                            end
                        end else begin
                            st_q <= RS_POST;
                        end
                    end
                end
                RS_WAIT: begin
                    if (rd_valid) begin
                        word_q <= rd_word;
                        st_q   <= RS_BEAT;
                    end
                end
                RS_POST: st_q <= RS_IDLE;
                default: st_q <= RS_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_ready = (st_q == RS_IDLE) || (st_q == RS_WAIT) ||
                   ((st_q == RS_BEAT) && pos_q.half && more_words);
    end

    always_comb begin
        int lo;
        lo      = pos_q.half ? 2 : 0;
        dq_oe   = (st_q == RS_BEAT);
        dq_rise = '0;
        dq_fall = '0;
        if (dq_oe) begin
            dq_rise = word_q[lo*DQ_W +: DQ_W];
            dq_fall = word_q[(lo+1)*DQ_W +: DQ_W];
        end
    end

    always_comb begin
        strb_en_r = (st_q != RS_IDLE);
        strb_en_f = (st_q == RS_PRE) || (st_q == RS_BEAT) || (st_q == RS_WAIT);
        strb_r    = (st_q == RS_BEAT);
        strb_f    = 1'b0;
    end

endmodule

// File: rtl/dbg_wr_lane.sv
module dbg_wr_lane
    import dbg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    edge_r,
    input  logic                    edge_f,
    input  logic [LANE_W-1:0]       d_r,
    input  logic [LANE_W-1:0]       d_f,
    input  logic                    clear,
    output logic                    full,
    output logic [BEATS_PER_WORD*LANE_W-1:0] lane_data
);

    logic [BEATS_PER_WORD-1:0][LANE_W-1:0] beats_q;
    logic full_q;
    logic slot_q;
    logic base;
    logic take;

    always_comb begin
        base = clear ? 1'b0 : slot_q;
        take = edge_r && edge_f && (!full_q || clear);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_q <= '0;
            full_q  <= 1'b0;
            slot_q  <= 1'b0;
        end else if (take) begin
            beats_q[{base, 1'b0}] <= d_r;
            beats_q[{base, 1'b1}] <= d_f;
            slot_q <= ~base;
            full_q <= base;
        end else if (clear) begin
            slot_q <= 1'b0;
            full_q <= 1'b0;
        end
    end

    assign full      = full_q;
    assign lane_data = beats_q;

endmodule

// File: rtl/dbg_wr_assemble.sv
module dbg_wr_assemble
    import dbg_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [DQ_W/LANE_W-1:0]                    lane_full,
    input  logic [DQ_W/LANE_W-1:0][BEATS_PER_WORD*LANE_W-1:0] lane_data,
    output logic                                      clear,
    output logic                                      wr_valid,
    output logic [BEATS_PER_WORD*DQ_W-1:0]            wr_word
);

    localparam int LANES  = DQ_W / LANE_W;
    localparam int WORD_W = BEATS_PER_WORD * DQ_W;

    logic [WORD_W-1:0] packed_w;

    for (genvar k = 0; k < BEATS_PER_WORD; k++) begin : g_beat
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign packed_w[lane_bit(k, b, DQ_W) +: LANE_W] = lane_data[b][k*LANE_W +: LANE_W];
        end
    end

    assign clear = &lane_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_word  <= '0;
        end else begin
            wr_valid <= clear;
            if (clear) begin
                wr_word <= packed_w;
            end
        end
    end

endmodule

// File: rtl/ddr_burst_gearbox.sv
module ddr_burst_gearbox
    import dbg_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bl8_cfg,
    input  logic                          rd_valid,
    input  logic [4*DQ_W-1:0]             rd_word,
    output logic                          rd_ready,
    output logic                          dq_oe,
    output logic [DQ_W-1:0]               dq_rise,
    output logic [DQ_W-1:0]               dq_fall,
    output logic [DQ_W/8-1:0]             dqs_oe_rise,
    output logic [DQ_W/8-1:0]             dqs_oe_fall,
    output logic [DQ_W/8-1:0]             dqs_rise,
    output logic [DQ_W/8-1:0]             dqs_fall,
    input  logic [DQ_W-1:0]               wr_dq_rise,
    input  logic [DQ_W-1:0]               wr_dq_fall,
    input  logic [DQ_W/8-1:0]             wr_dqs_rise,
    input  logic [DQ_W/8-1:0]             wr_dqs_fall,
    output logic                          wr_valid,
    output logic [4*DQ_W-1:0]             wr_word
);

    localparam int LANES = DQ_W / LANE_W;

    logic strb_en_r, strb_en_f, strb_r, strb_f;
    logic wr_clear;
    logic [LANES-1:0] lane_full;
    logic [LANES-1:0][BEATS_PER_WORD*LANE_W-1:0] lane_data;

    dbg_rd_serializer #(.DQ_W(DQ_W)) rd_ser_i (
        .clk       (clk),
        .rst       (rst),
        .bl8_cfg   (bl8_cfg),
        .rd_valid  (rd_valid),
        .rd_word   (rd_word),
        .rd_ready  (rd_ready),
        .dq_oe     (dq_oe),
        .dq_rise   (dq_rise),
        .dq_fall   (dq_fall),
        .strb_en_r (strb_en_r),
        .strb_en_f (strb_en_f),
        .strb_r    (strb_r),
        .strb_f    (strb_f)
    );

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign dqs_oe_rise[b] = strb_en_r;
        assign dqs_oe_fall[b] = strb_en_f;
        assign dqs_rise[b]    = strb_r;
        assign dqs_fall[b]    = strb_f;

        dbg_wr_lane wr_lane_i (
            .clk       (clk),
            .rst       (rst),
            .edge_r    (wr_dqs_rise[b]),
            .edge_f    (wr_dqs_fall[b]),
            .d_r       (wr_dq_rise[b*LANE_W +: LANE_W]),
            .d_f       (wr_dq_fall[b*LANE_W +: LANE_W]),
            .clear     (wr_clear),
            .full      (lane_full[b]),
            .lane_data (lane_data[b])
        );
    end

    dbg_wr_assemble #(.DQ_W(DQ_W)) wr_asm_i (
        .clk       (clk),
        .rst       (rst),
        .lane_full (lane_full),
        .lane_data (lane_data),
        .clear     (wr_clear),
        .wr_valid  (wr_valid),
        .wr_word   (wr_word)
    );

endmodule

// File: rtl/dbg_checker.sv
module dbg_checker #(
    parameter int DQ_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic             dq_oe,
    input logic [DQ_W/8-1:0] dqs_oe_rise,
    input logic [DQ_W/8-1:0] dqs_oe_fall,
    input logic [DQ_W/8-1:0] dqs_rise,
    input logic             wr_valid
);

    localparam logic [DQ_W/8-1:0] ALL = {(DQ_W/8){1'b1}};

    AST_PREAMBLE_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> $past(dqs_oe_rise == ALL && dqs_oe_fall == ALL && dqs_rise == '0)); // R2

    AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (dqs_rise == ALL && dqs_oe_rise == ALL && dqs_oe_fall == ALL)); // R3

    AST_POSTAMBLE_HALF: assert property (@(posedge clk) disable iff (rst)
        (dqs_oe_rise == ALL && dqs_oe_fall == '0) |-> (!dq_oe && dqs_rise == '0 && $past(dq_oe))); // R7

    AST_POSTAMBLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (dqs_oe_rise == ALL && dqs_oe_fall == '0) |=> (dqs_oe_rise == '0)); // R7

    AST_STALL_RESUME: assert property (@(posedge clk) disable iff (rst)
        (dqs_oe_fall == ALL && !dq_oe && rd_ready && rd_valid) |=> dq_oe); // R6

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        (dqs_oe_rise == '0) |-> rd_ready); // R1

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid); // R10

endmodule

bind ddr_burst_gearbox dbg_checker #(.DQ_W(DQ_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .dq_oe       (dq_oe),
    .dqs_oe_rise (dqs_oe_rise),
    .dqs_oe_fall (dqs_oe_fall),
    .dqs_rise    (dqs_rise),
    .wr_valid    (wr_valid)
);

// File: tb/ddr_burst_gearbox_tb_top.sv
`timescale 1ns/1ps
module ddr_burst_gearbox_tb_top;

    localparam int DQ_W = 16;
    localparam int NB   = DQ_W / 8;
    localparam int WW   = 4 * DQ_W;
    localparam logic [NB-1:0] ALL = {NB{1'b1}};
    localparam logic [WW-1:0] JUNK = 64'h5A5A_A5A5_3C3C_C3C3;

    typedef struct packed {
        logic [63:0] w0;
        logic [63:0] w1;
        logic        bl8;
        logic [3:0]  stall;
    } rd_vec_t;

    localparam int NVEC = 5;
    localparam rd_vec_t VECS [NVEC] = '{
        '{64'h4444_3333_2222_1111, 64'h0,                   1'b0, 4'd0},
        '{64'hA1A2_B3B4_C5C6_D7D8, 64'h1357_2468_9ACE_BDF0, 1'b1, 4'd0},
        '{64'hFFFF_0000_FFFF_0000, 64'h0001_8000_7FFE_0002, 1'b1, 4'd1},
        '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1, 4'd3},
        '{64'hDEAD_BEEF_CAFE_F00D, 64'h0,                   1'b0, 4'd0}
    };

    logic clk = 1'b0;
    logic rst;
    logic bl8_cfg, rd_valid;
    logic [WW-1:0] rd_word;
    logic rd_ready, dq_oe;
    logic [DQ_W-1:0] dq_rise, dq_fall;
    logic [NB-1:0] dqs_oe_rise, dqs_oe_fall, dqs_rise, dqs_fall;
    logic [DQ_W-1:0] wr_dq_rise, wr_dq_fall;
    logic [NB-1:0] wr_dqs_rise, wr_dqs_fall;
    logic wr_valid;
    logic [WW-1:0] wr_word;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    ddr_burst_gearbox #(.DQ_W(DQ_W)) dut_i (
        .clk(clk), .rst(rst), .bl8_cfg(bl8_cfg), .rd_valid(rd_valid), .rd_word(rd_word),
        .rd_ready(rd_ready), .dq_oe(dq_oe), .dq_rise(dq_rise), .dq_fall(dq_fall),
        .dqs_oe_rise(dqs_oe_rise), .dqs_oe_fall(dqs_oe_fall), .dqs_rise(dqs_rise),
        .dqs_fall(dqs_fall), .wr_dq_rise(wr_dq_rise), .wr_dq_fall(wr_dq_fall),
        .wr_dqs_rise(wr_dqs_rise), .wr_dqs_fall(wr_dqs_fall), .wr_valid(wr_valid),
        .wr_word(wr_word)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DQ_W-1:0] beat(input logic [WW-1:0] w, input int i);
        return w[i*DQ_W +: DQ_W];
    endfunction

    task automatic check_beats(input logic [WW-1:0] w, input int first);
        chk(dq_oe === 1'b1 && dq_rise === beat(w, first), "R3 rise beat",
            {47'b0, dq_oe, dq_rise}, {47'b0, 1'b1, beat(w, first)});
        chk(dq_fall === beat(w, first+1) && dqs_rise === ALL && dqs_fall === '0, "R3 fall beat/strobe",
            {44'b0, dqs_rise, dq_fall}, {44'b0, ALL, beat(w, first+1)});
    endtask

    task automatic strobe_low_check(input string req);
        chk(dq_oe === 1'b0 && dqs_oe_rise === ALL && dqs_oe_fall === ALL && dqs_rise === '0 && dqs_fall === '0,
            req, {57'b0, dq_oe, dqs_oe_rise, dqs_oe_fall, dqs_rise},
            {57'b0, 1'b0, ALL, ALL, {NB{1'b0}}});
    endtask

    task automatic run_read(input rd_vec_t v);
        rd_valid = 1'b1; rd_word = v.w0; bl8_cfg = v.bl8;
        chk(rd_ready === 1'b1, "R8 idle ready", {63'b0, rd_ready}, 64'd1);
        tick();
        // preamble; offer junk and flip config, both to be ignored
        rd_word = JUNK; bl8_cfg = ~v.bl8;
        strobe_low_check("R2 preamble");
        chk(rd_ready === 1'b0, "R8 ready low in preamble", {63'b0, rd_ready}, 64'd0);
        tick();
        check_beats(v.w0, 0);
        chk(rd_ready === 1'b0, "R8 ready low first beat clock", {63'b0, rd_ready}, 64'd0);
        if (v.bl8) begin
            rd_valid = (v.stall == 0);
            rd_word  = v.w1;
        end
        tick();
        check_beats(v.w0, 2);
        chk(rd_ready === v.bl8, "R5 ready at second beat clock (R4 length)", {63'b0, rd_ready}, {63'b0, v.bl8});
        if (v.bl8) begin
            for (int i = 0; i < int'(v.stall); i++) begin
                tick();
                strobe_low_check("R6 stall strobe");
                chk(rd_ready === 1'b1, "R6 ready during stall", {63'b0, rd_ready}, 64'd1);
            end
            rd_valid = 1'b1; rd_word = v.w1;
            tick();
            check_beats(v.w1, 4 - 4);
            chk(rd_ready === 1'b0, "R8 ready low second word", {63'b0, rd_ready}, 64'd0);
            rd_valid = 1'b1; rd_word = JUNK;
            tick();
            check_beats(v.w1, 2);
        end
        rd_valid = 1'b0;
        tick();
        chk(dqs_oe_rise === ALL && dqs_oe_fall === '0 && dqs_rise === '0 && dq_oe === 1'b0,
            "R7 postamble", {58'b0, dq_oe, dqs_oe_rise, dqs_oe_fall, 1'b0},
            {58'b0, 1'b0, ALL, {NB{1'b0}}, 1'b0});
        tick();
        chk(dqs_oe_rise === '0 && dqs_oe_fall === '0 && rd_ready === 1'b1, "R7 strobe released",
            {59'b0, rd_ready, dqs_oe_rise, dqs_oe_fall}, {59'b0, 1'b1, {NB{1'b0}}, {NB{1'b0}}});
    endtask

    task automatic drive_wr(input logic [1:0] r, input logic [1:0] f,
                            input logic [7:0] l0r, input logic [7:0] l0f,
                            input logic [7:0] l1r, input logic [7:0] l1f);
        wr_dqs_rise = r; wr_dqs_fall = f;
        wr_dq_rise = {l1r, l0r}; wr_dq_fall = {l1f, l0f};
    endtask

    task automatic chk_wr(input logic exp_v, input logic [63:0] exp_w, input string req);
        if (exp_v)
            chk(wr_valid === 1'b1 && wr_word === exp_w, req, wr_word, exp_w);
        else
            chk(wr_valid === 1'b0, req, {63'b0, wr_valid}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bl8_cfg = 1'b0; rd_valid = 1'b0; rd_word = '0;
        drive_wr(2'b00, 2'b00, 8'h0, 8'h0, 8'h0, 8'h0);
        repeat (3) tick();
        rst = 1'b0;
        #0;
        // R1 reset state
        chk(dq_oe === 1'b0 && dqs_oe_rise === '0 && dqs_oe_fall === '0, "R1 read idle",
            {59'b0, dq_oe, dqs_oe_rise, dqs_oe_fall}, 64'd0);
        chk(rd_ready === 1'b1 && wr_valid === 1'b0, "R1 ready/wr_valid",
            {62'b0, rd_ready, wr_valid}, 64'd2);

        for (int n = 0; n < NVEC; n++) run_read(VECS[n]);

        // R9 R10: aligned lanes, then back-to-back word captured on the clear edge
        drive_wr(2'b11, 2'b11, 8'hA0, 8'hA1, 8'hB0, 8'hB1);
        tick();
        drive_wr(2'b11, 2'b11, 8'hA2, 8'hA3, 8'hB2, 8'hB3);
        tick();
        chk_wr(1'b0, 64'h0, "R10 no early valid");
        drive_wr(2'b11, 2'b11, 8'hC0, 8'hC1, 8'hD0, 8'hD1);
        tick();
        chk_wr(1'b1, 64'hB3A3_B2A2_B1A1_B0A0, "R9 aligned word");
        drive_wr(2'b11, 2'b11, 8'hC2, 8'hC3, 8'hD2, 8'hD3);
        tick();
        chk_wr(1'b0, 64'h0, "R10 single-clock pulse");
        drive_wr(2'b00, 2'b00, 8'h0, 8'h0, 8'h0, 8'h0);
        tick();
        chk_wr(1'b1, 64'hD3C3_D2C2_D1C1_D0C0, "R10 word started on clear edge");
        tick();
        chk_wr(1'b0, 64'h0, "R10 valid drops");

        // R11: lane1 one-edge clock ignored; lane0 full ignores an extra pair; skew
        drive_wr(2'b11, 2'b01, 8'h10, 8'h11, 8'hEE, 8'hEF);
        tick();
        drive_wr(2'b11, 2'b11, 8'h12, 8'h13, 8'h20, 8'h21);
        tick();
        chk_wr(1'b0, 64'h0, "R11 lane1 not yet full");
        drive_wr(2'b11, 2'b11, 8'h99, 8'h98, 8'h22, 8'h23);
        tick();
        chk_wr(1'b0, 64'h0, "R10 valid only after last lane fills");
        drive_wr(2'b00, 2'b00, 8'h0, 8'h0, 8'h0, 8'h0);
        tick();
        chk_wr(1'b1, 64'h2313_2212_2111_2010, "R11 skewed word, extra and one-edge ignored");
        tick();
        chk_wr(1'b0, 64'h0, "R10 valid drops after skewed word");

        // reset mid-burst returns to idle
        rd_valid = 1'b1; rd_word = JUNK; bl8_cfg = 1'b1;
        tick(); tick();
        rst = 1'b1; rd_valid = 1'b0;
        tick();
        rst = 1'b0;
        #0;
        chk(dq_oe === 1'b0 && dqs_oe_rise === '0 && rd_ready === 1'b1, "R1 reset during burst",
            {60'b0, dq_oe, rd_ready, dqs_oe_rise}, {60'b0, 1'b0, 1'b1, {NB{1'b0}}});

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule